// File: doc/BRIEF.md
# Calibration Overlay Burst Read Assembler

This block stands in for one wide flash fetch when a calibration read has been redirected to overlay memory. It takes a translated, physical byte address and a selector naming the overlay target. It then reads four 32-bit words, one after another, from that target over a private narrow port, and packs them into a single 128-bit line for the flash read-data path. Every request it places on the narrow port is flagged as top priority for the memory controller. This keeps the time for a full line close to the time for a native flash access.

The narrow port uses a two-step handshake for each beat. First the block holds a request until the target grants it. Then it waits for a response strobe that carries the data. Only one beat is in flight at a time. When the fourth word has been captured, the block raises a one-cycle line-ready pulse with the assembled line. Only after that pulse does it accept the next line request.

Top module: `cal_ovl_burst_asm`

## Requirements
- R1: `line_req_ready` is high exactly when the block is idle. A line request is taken only on a clock edge where both `line_req_valid` and `line_req_ready` are high. While a burst is in progress, a held `line_req_valid` starts no further beats.
- R2: Each accepted line request produces exactly four granted beat requests. During the whole burst, `ovl_tgt` carries the target selector that was captured at acceptance.
- R3: Beat k (k = 0..3) requests byte address `(line_addr & ~0xF) + 4*k`. Bits [3:0] of the request address are therefore ignored.
- R4: `ovl_hiprio` is high in every cycle in which `ovl_req_valid` is high.
- R5: A beat request stays asserted, with a stable address, until `ovl_req_ready` is seen. The next beat is not requested until the previous beat's data has returned, so at most one beat is outstanding.
- R6: Data is captured only on a cycle where `ovl_rvalid` is high after the current beat has been granted. An `ovl_rvalid` pulse in any other cycle (idle, or while a request is still waiting for its grant) has no effect on the line.
- R7: Beat k supplies bits [32k+31:32k] of `line_data`. Bits [31:0] come from the word at the line-aligned base address.
- R8: `line_done` is high for exactly one cycle. That cycle immediately follows the clock edge at which the fourth beat's data was captured, and `line_data` then holds the full line.
- R9: A synchronous active-low reset returns the block to idle with the beat counter cleared. After reset, `line_req_ready` is 1, `ovl_req_valid` and `line_done` are 0, `line_data` is 0, and the next burst starts at beat 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_req_valid | input | 1 | A line read is requested |
| line_req_ready | output | 1 | Block is idle and can take a line request |
| line_addr | input | 32 | Translated physical byte address of the line |
| line_tgt | input | 2 | Overlay target selector (0 system RAM, 1 on-chip overlay, 2 external overlay) |
| ovl_req_valid | output | 1 | Beat request toward the overlay target |
| ovl_req_ready | input | 1 | Target grants the current beat request |
| ovl_addr | output | 32 | Byte address of the current beat |
| ovl_tgt | output | 2 | Target selector for the current burst |
| ovl_hiprio | output | 1 | Top-priority flag accompanying each beat request |
| ovl_rvalid | input | 1 | Beat read data is valid |
| ovl_rdata | input | 32 | Beat read data |
| line_done | output | 1 | One-cycle pulse: assembled line is ready |
| line_data | output | 128 | Assembled 128-bit line |

## Verification
The hardest case to reach from the ports is a response strobe that arrives when no beat is outstanding. This can happen while a request is still waiting for its grant, or while the block sits idle. A correct design must ignore it, yet a careless design would quietly corrupt one lane of the line. The bench's target model therefore holds back its grant for several cycles and sends junk data with the response strobe raised during those cycles and during idle. It then checks that the finished line and the held `line_data` contain only the data from granted beats. A reset in the middle of a burst, followed by a fresh burst, shows that the beat counter restarts at beat 0.

// File: rtl/cal_ovl_pkg.sv
// Package: shared types for the calibration overlay burst assembler.
// Assumes: one beat in flight at a time; the state encoding is local to this block.
package cal_ovl_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_ISSUE = 2'd1,
        SEQ_WAIT  = 2'd2,
        SEQ_DONE  = 2'd3
    } seq_state_t;

endpackage

// File: rtl/cal_ovl_beat_seq.sv
// Beat sequencer: accepts a line request, walks NBEATS beats through a
// request/grant then response handshake, and flags completion.
// Assumes: NBEATS is a power of two; the line is NBEATS*BEAT_W bits and
// naturally aligned, so beat addresses need no adder.
module cal_ovl_beat_seq
    import cal_ovl_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int BEAT_W = 32,
    parameter int NBEATS = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      line_req_valid,
    input  logic [ADDR_W-1:0]         line_addr,
    output logic                      line_req_ready,
    output logic                      ovl_req_valid,
    input  logic                      ovl_req_ready,
    input  logic                      ovl_rvalid,
    output logic [ADDR_W-1:0]         ovl_addr,
    output logic                      cap_en,
    output logic [$clog2(NBEATS)-1:0] cap_idx,
    output logic                      line_done
);
    localparam int CNT_W    = $clog2(NBEATS);
    localparam int BSH      = $clog2(BEAT_W / 8);
    localparam int OFS_W    = CNT_W + BSH;
    localparam int HI_W     = ADDR_W - OFS_W;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(NBEATS - 1);

    seq_state_t       state_q;
    logic [CNT_W-1:0] cnt_q;
    logic [HI_W-1:0]  base_hi_q;

    assign line_req_ready = (state_q == SEQ_IDLE);
    assign ovl_req_valid  = (state_q == SEQ_ISSUE);
    assign line_done      = (state_q == SEQ_DONE);
    assign cap_en         = (state_q == SEQ_WAIT) && ovl_rvalid;
    assign cap_idx        = cnt_q;
    assign ovl_addr       = {base_hi_q, cnt_q, {BSH{1'b0}}};

    // Purpose: advance the beat state machine, beat counter and line base.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= SEQ_IDLE;
            cnt_q     <= '0;
            base_hi_q <= '0;
        end else begin
            unique case (state_q)
                SEQ_IDLE: if (line_req_valid) begin
                    base_hi_q <= line_addr[ADDR_W-1:OFS_W];
                    cnt_q     <= '0;
                    state_q   <= SEQ_ISSUE;
                end
                SEQ_ISSUE: if (ovl_req_ready) state_q <= SEQ_WAIT;
                SEQ_WAIT: if (ovl_rvalid) begin
                    if (cnt_q == LAST) begin
                        state_q <= SEQ_DONE;
                    end else begin
                        cnt_q   <= cnt_q + 1'b1;
                        state_q <= SEQ_ISSUE;
                    end
                end
                SEQ_DONE: begin
                    cnt_q   <= '0;
                    state_q <= SEQ_IDLE;
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/cal_ovl_line_pack.sv
// Line packer: one register lane per beat; lane k loads the beat data when
// the sequencer captures beat k. Assumes cap_idx is in range 0..NBEATS-1.
module cal_ovl_line_pack #(
    parameter int BEAT_W = 32,
    parameter int NBEATS = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cap_en,
    input  logic [$clog2(NBEATS)-1:0]  cap_idx,
    input  logic [BEAT_W-1:0]          beat_data,
    output logic [NBEATS*BEAT_W-1:0]   line_data
);
    for (genvar g = 0; g < NBEATS; g++) begin : g_lane
        logic [BEAT_W-1:0] lane_q;

        // Purpose: hold the data word of beat g of the current line.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lane_q <= '0;
            end else if (cap_en && (cap_idx == g)) begin
                lane_q <= beat_data;
            end
        end

        assign line_data[g*BEAT_W +: BEAT_W] = lane_q;
    end
endmodule

// File: rtl/cal_ovl_burst_asm.sv
// Top: turns one line read into NBEATS narrow beats to an overlay target,
// all flagged top priority, and packs them into one line.
// Assumes: the target answers each granted beat exactly once with rvalid.
module cal_ovl_burst_asm #(
    parameter int ADDR_W = 32,
    parameter int BEAT_W = 32,
    parameter int LINE_W = 128,
    parameter int TGT_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_req_valid,
    output logic              line_req_ready,
    input  logic [ADDR_W-1:0] line_addr,
    input  logic [TGT_W-1:0]  line_tgt,
    output logic              ovl_req_valid,
    input  logic              ovl_req_ready,
    output logic [ADDR_W-1:0] ovl_addr,
    output logic [TGT_W-1:0]  ovl_tgt,
    output logic              ovl_hiprio,
    input  logic              ovl_rvalid,
    input  logic [BEAT_W-1:0] ovl_rdata,
    output logic              line_done,
    output logic [LINE_W-1:0] line_data
);
    localparam int NBEATS = LINE_W / BEAT_W;
    localparam int CNT_W  = $clog2(NBEATS);

    logic             cap_en;
    logic [CNT_W-1:0] cap_idx;
    logic [TGT_W-1:0] tgt_q;

    cal_ovl_beat_seq #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W), .NBEATS(NBEATS)) u_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .line_req_valid (line_req_valid),
        .line_addr      (line_addr),
        .line_req_ready (line_req_ready),
        .ovl_req_valid  (ovl_req_valid),
        .ovl_req_ready  (ovl_req_ready),
        .ovl_rvalid     (ovl_rvalid),
        .ovl_addr       (ovl_addr),
        .cap_en         (cap_en),
        .cap_idx        (cap_idx),
        .line_done      (line_done)
    );

    cal_ovl_line_pack #(.BEAT_W(BEAT_W), .NBEATS(NBEATS)) u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_en    (cap_en),
        .cap_idx   (cap_idx),
        .beat_data (ovl_rdata),
        .line_data (line_data)
    );

    // Purpose: keep the target selector of the accepted line for the whole burst.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt_q <= '0;
        end else if (line_req_valid && line_req_ready) begin
            tgt_q <= line_tgt;
        end
    end

    assign ovl_tgt    = tgt_q;
    assign ovl_hiprio = ovl_req_valid;
endmodule

// File: rtl/cal_ovl_burst_asm_chk.sv
// Checker: temporal properties of the burst assembler's ports, bound to the top.
module cal_ovl_burst_asm_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              line_req_ready,
    input logic              ovl_req_valid,
    input logic              ovl_req_ready,
    input logic [ADDR_W-1:0] ovl_addr,
    input logic              ovl_hiprio,
    input logic              ovl_rvalid,
    input logic              line_done
);
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        line_req_ready |-> (!ovl_req_valid && !line_done));

    a_r3_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        ovl_req_valid |-> (ovl_addr[1:0] == 2'b00));

    a_r4_hiprio: assert property (@(posedge clk) disable iff (!rst_n)
        ovl_req_valid |-> ovl_hiprio);

    a_r5_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
        (ovl_req_valid && !ovl_req_ready) |=> (ovl_req_valid && $stable(ovl_addr)));

    a_r5_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        (ovl_req_valid && ovl_req_ready) |=> !ovl_req_valid);

    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        line_done |=> !line_done);

    a_r8_after_capture: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(line_done) |-> $past(ovl_rvalid));

    a_r9_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (line_req_ready && !ovl_req_valid && !line_done));
endmodule

bind cal_ovl_burst_asm cal_ovl_burst_asm_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .line_req_ready (line_req_ready),
    .ovl_req_valid  (ovl_req_valid),
    .ovl_req_ready  (ovl_req_ready),
    .ovl_addr       (ovl_addr),
    .ovl_hiprio     (ovl_hiprio),
    .ovl_rvalid     (ovl_rvalid),
    .line_done      (line_done)
);

// File: tb/cal_ovl_burst_asm_test.sv
module cal_ovl_burst_asm_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         line_req_valid = 1'b0;
    logic         line_req_ready;
    logic [31:0]  line_addr = '0;
    logic [1:0]   line_tgt = '0;
    logic         ovl_req_valid;
    logic         ovl_req_ready = 1'b0;
    logic [31:0]  ovl_addr;
    logic [1:0]   ovl_tgt;
    logic         ovl_hiprio;
    logic         ovl_rvalid = 1'b0;
    logic [31:0]  ovl_rdata = '0;
    logic         line_done;
    logic [127:0] line_data;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;

    // target model configuration and records
    int          cfg_gnt = 0;
    int          cfg_rsp = 0;
    bit          cfg_stray = 1'b0;
    logic [1:0]  exp_tgt = '0;
    int          beats = 0;
    logic [31:0] rec_addr [0:7];
    int          tgt_bad = 0;
    int          prio_bad = 0;
    int          overlap_bad = 0;
    bit          pending = 1'b0;
    int          lat = 0;
    int          wcnt = 0;
    logic [31:0] paddr = '0;

    cal_ovl_burst_asm uut (
        .clk(clk), .rst_n(rst_n),
        .line_req_valid(line_req_valid), .line_req_ready(line_req_ready),
        .line_addr(line_addr), .line_tgt(line_tgt),
        .ovl_req_valid(ovl_req_valid), .ovl_req_ready(ovl_req_ready),
        .ovl_addr(ovl_addr), .ovl_tgt(ovl_tgt), .ovl_hiprio(ovl_hiprio),
        .ovl_rvalid(ovl_rvalid), .ovl_rdata(ovl_rdata),
        .line_done(line_done), .line_data(line_data)
    );

    always #5 clk = ~clk;

    function automatic logic [31:0] fdat(input logic [31:0] a);
        return {a[15:0] ^ 16'h5A3C, ~a[15:0]};
    endfunction

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Overlay target model: grant after cfg_gnt waiting cycles, answer cfg_rsp cycles later.
    always @(negedge clk) begin
        cycles++;
        ovl_req_ready = 1'b0;
        ovl_rvalid    = 1'b0;
        ovl_rdata     = '0;
        if (!rst_n) begin
            pending = 1'b0;
            wcnt    = 0;
        end else if (pending) begin
            if (ovl_req_valid) overlap_bad++;
            if (lat == 0) begin
                ovl_rvalid = 1'b1;
                ovl_rdata  = fdat(paddr);
                pending    = 1'b0;
            end else begin
                lat--;
            end
        end else if (ovl_req_valid) begin
            if (!ovl_hiprio) prio_bad++;
            if (ovl_tgt !== exp_tgt) tgt_bad++;
            if (wcnt >= cfg_gnt) begin
                ovl_req_ready = 1'b1;
                if (beats < 8) rec_addr[beats] = ovl_addr;
                beats++;
                paddr   = ovl_addr;
                pending = 1'b1;
                lat     = cfg_rsp;
                wcnt    = 0;
            end else begin
                wcnt++;
                if (cfg_stray) begin
                    ovl_rvalid = 1'b1;
                    ovl_rdata  = 32'hDEAD_BEEF;
                end
            end
        end else if (cfg_stray) begin
            ovl_rvalid = 1'b1;
            ovl_rdata  = 32'hBAD0_F00D;
        end
    end

    // Watchdog: a hung run counts as a failed check and still prints the summary.
    always @(posedge clk) begin
        if (cycles > 50000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected<=50000 cycles", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    function automatic logic [127:0] exp_line(input logic [31:0] a);
        logic [127:0] l;
        logic [31:0]  b;
        b = {a[31:4], 4'h0};
        for (int k = 0; k < 4; k++) l[32*k +: 32] = fdat(b + 32'(4 * k));
        return l;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        line_req_valid = 1'b0;
        repeat (2) @(negedge clk);
        check("R9 ready after reset", 128'(line_req_ready), 128'd1);
        check("R9 no beat request after reset", 128'(ovl_req_valid), 128'd0);
        check("R9 no line pulse after reset", 128'(line_done), 128'd0);
        check("R9 line cleared after reset", line_data, 128'd0);
        rst_n = 1'b1;
    endtask

    // Run one line request; optionally keep the request held during the burst.
    task automatic run_line(input string name, input logic [31:0] a, input logic [1:0] t,
                            input int gd, input int rd, input bit stray, input bit hold);
        int w;
        logic [31:0] b;
        cfg_gnt = gd; cfg_rsp = rd; cfg_stray = stray; exp_tgt = t;
        beats = 0; tgt_bad = 0; prio_bad = 0; overlap_bad = 0;
        b = {a[31:4], 4'h0};
        @(negedge clk);
        check({name, " R1 ready when idle"}, 128'(line_req_ready), 128'd1);
        line_req_valid = 1'b1; line_addr = a; line_tgt = t;
        @(negedge clk);
        if (!hold) line_req_valid = 1'b0;
        check({name, " R1 busy after accept"}, 128'(line_req_ready), 128'd0);
        w = 0;
        while (!line_done && w < 500) begin
            @(negedge clk);
            w++;
        end
        line_req_valid = 1'b0;
        check({name, " R8 line pulse seen"}, 128'(line_done), 128'd1);
        check({name, " R7 line data"}, line_data, exp_line(a));
        check({name, " R2 four beats"}, 128'(beats), 128'd4);
        for (int k = 0; k < 4; k++)
            check({name, " R3 beat address"}, 128'(rec_addr[k]), 128'(b + 32'(4 * k)));
        check({name, " R2 target forwarded"}, 128'(tgt_bad), 128'd0);
        check({name, " R4 priority flag"}, 128'(prio_bad), 128'd0);
        check({name, " R5 one outstanding"}, 128'(overlap_bad), 128'd0);
        @(negedge clk);
        check({name, " R8 single-cycle pulse"}, 128'(line_done), 128'd0);
        if (hold) check({name, " R1 no extra beats while held"}, 128'(beats), 128'd4);
        repeat (3) @(negedge clk);
        check({name, " R6 line held in idle"}, line_data, exp_line(a));
        cfg_stray = 1'b0;
    endtask

    task automatic reset_mid_burst();
        int w;
        cfg_gnt = 0; cfg_rsp = 2; cfg_stray = 0; exp_tgt = 2'd1; beats = 0;
        @(negedge clk);
        line_req_valid = 1'b1; line_addr = 32'h0000_2230; line_tgt = 2'd1;
        @(negedge clk);
        line_req_valid = 1'b0;
        w = 0;
        while (beats < 2 && w < 200) begin
            @(negedge clk);
            w++;
        end
        do_reset();
        run_line("after_reset", 32'h0000_5550, 2'd0, 0, 0, 0, 0);
        check("R9 restart at beat 0", 128'(rec_addr[0]), 128'h0000_5550);
    endtask

    initial begin
        do_reset();
        run_line("sysram_fast", 32'h0001_0000, 2'd0, 0, 0, 0, 0);
        run_line("unaligned", 32'h0ABC_DEF7, 2'd0, 1, 1, 0, 0);
        run_line("onchip_slow", 32'h0C00_1238, 2'd1, 3, 4, 0, 0);
        run_line("stray_rvalid", 32'h0D00_0F40, 2'd2, 3, 2, 1, 0);
        run_line("held_request", 32'hFFFF_FFF0, 2'd2, 2, 0, 0, 1);
        reset_mid_burst();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule